// File: doc/BRIEF.md
# Polled Console Register Block

This block sits on a processor's 16-bit memory bus and claims four word addresses for a character console. Two of them serve a keyboard: a byte arriving on a valid/ready input stream is latched and flagged, and software collects it by reading a data word. The other two serve a display: software writes a character to a data word, and the block presents it on a valid/ready output stream until the downstream side takes it.

There are no interrupts. Software polls the two status words, and readiness sits in bit 15 of each. A loaded status value is therefore negative when the device is ready and non-negative while the program must keep looping. Any bus access to an address outside the four is flagged on a separate select output, so ordinary memory can answer it.

Read data is combinational from the address and present state, in the same cycle as the read strobe. Every state change caused by an access takes effect at the clock edge that ends that cycle.

Top module: `console_mmio`

## Requirements
- R1: After reset the keyboard input ready is 1, the display output valid is 0, the keyboard status word (xFE00) reads 16'h0000 and the display status word (xFE04) reads 16'h8000.
- R2: A byte taken on the keyboard input (valid and ready both high at a clock edge) makes keyboard input ready 0 and the keyboard status word read 16'h8000 from the next cycle on.
- R3: A read of the keyboard data word (xFE02) returns the held byte in bits 7:0 with bits 15:8 zero. After that cycle's edge, keyboard input ready is 1 and the keyboard status word reads 16'h0000.
- R4: While a byte is held, the keyboard input ready stays 0 and bytes offered on the input are not taken; the held byte is unchanged.
- R5: A write to the display data word (xFE06) while the display status reads 16'h8000 makes the output valid 1 in the next cycle, carrying bits 7:0 of the written word. The display status word then reads 16'h0000.
- R6: While output valid is 1 and output ready is 0, valid and the output character stay unchanged. After an edge at which both are 1, valid is 0 and the display status reads 16'h8000.
- R7: A write to the display data word while a character is still pending is dropped, and the pending character is unchanged.
- R8: Writes to either status word and to the keyboard data word change nothing. A read of the display data word returns 16'h0000, and reads of the status words have no side effect.
- R9: The memory select output is 1 exactly when a read or write strobe is high and the address is none of the four console words. Such accesses read 16'h0000 from the block and change no console state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 16 | Word address of the current access |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for console addresses, zero otherwise |
| mem_sel | output | 1 | Access goes to ordinary memory |
| kb_in_valid | input | 1 | Keyboard byte offered |
| kb_in_data | input | 8 | Keyboard byte |
| kb_in_ready | output | 1 | Block can take a keyboard byte |
| dsp_out_valid | output | 1 | Display character pending |
| dsp_out_data | output | 8 | Display character |
| dsp_out_ready | input | 1 | Display takes the character |

## Verification
Read data and the memory select are combinational. The bench samples them one nanosecond after it drives the address and strobe, which is before the edge that commits the access. Every registered effect (keyboard ready, status bit 15, display valid and character) is due one edge after the handshake or bus access that causes it, and the bench samples it just after that edge. All 256 keyboard bytes and all 256 display characters are swept, with display stalls of zero to three cycles. An address window around the console words is also swept to check memory select and zero read data.

// File: rtl/console_pkg.sv
package console_pkg;
  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_KSTAT,
    SEL_KDATA,
    SEL_DSTAT,
    SEL_DDATA
  } reg_sel_e;
endpackage

// File: rtl/console_rst_sync.sv
module console_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/console_decode.sv
module console_decode
  import console_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] KSTAT_ADDR = 16'hFE00,
  parameter logic [ADDR_W-1:0] KDATA_ADDR = 16'hFE02,
  parameter logic [ADDR_W-1:0] DSTAT_ADDR = 16'hFE04,
  parameter logic [ADDR_W-1:0] DDATA_ADDR = 16'hFE06
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  output reg_sel_e          sel,
  output logic              mem_sel
);
  localparam int N_REGS = 4;
  localparam logic [ADDR_W-1:0] MAP [N_REGS] = '{KSTAT_ADDR, KDATA_ADDR, DSTAT_ADDR, DDATA_ADDR};
  localparam reg_sel_e CODE [N_REGS] = '{SEL_KSTAT, SEL_KDATA, SEL_DSTAT, SEL_DDATA};

  logic [N_REGS-1:0] hit;

  for (genvar i = 0; i < N_REGS; i++) begin : g_hit
    assign hit[i] = (addr == MAP[i]);
  end

  always_comb begin
    sel = SEL_NONE;
    for (int i = 0; i < N_REGS; i++) begin
      if (hit[i]) sel = CODE[i];
    end
  end

  assign mem_sel = (rd | wr) & ~(|hit);
endmodule

// File: rtl/console_kbd.sv
module console_kbd #(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [CHAR_W-1:0] in_data,
  output logic              in_ready,
  input  logic              consume,
  output logic              full,
  output logic [CHAR_W-1:0] char_q
);
  logic              full_d;
  logic              take;
  logic              char_en;

  assign in_ready = ~full;
  assign take     = in_valid & ~full;
  assign char_en  = take;

  always_comb begin
    full_d = full;
    if (take)         full_d = 1'b1;
    else if (consume) full_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) full <= 1'b0;
    else        full <= full_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       char_q <= '0;
    else if (char_en) char_q <= in_data;
  end
endmodule

// File: rtl/console_dsp.sv
module console_dsp #(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [CHAR_W-1:0] load_data,
  output logic              out_valid,
  output logic [CHAR_W-1:0] out_data,
  input  logic              out_ready,
  output logic              busy
);
  logic busy_d;
  logic accept;

  assign accept = load & ~busy;

  always_comb begin
    busy_d = busy;
    if (accept)                busy_d = 1'b1;
    else if (busy & out_ready) busy_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy <= 1'b0;
    else        busy <= busy_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      out_data <= '0;
    else if (accept) out_data <= load_data;
  end

  assign out_valid = busy;
endmodule

// File: rtl/console_mmio.sv
module console_mmio
  import console_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int CHAR_W = 8,
  parameter logic [ADDR_W-1:0] KSTAT_ADDR = 16'hFE00,
  parameter logic [ADDR_W-1:0] KDATA_ADDR = 16'hFE02,
  parameter logic [ADDR_W-1:0] DSTAT_ADDR = 16'hFE04,
  parameter logic [ADDR_W-1:0] DDATA_ADDR = 16'hFE06
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              mem_sel,
  input  logic              kb_in_valid,
  input  logic [CHAR_W-1:0] kb_in_data,
  output logic              kb_in_ready,
  output logic              dsp_out_valid,
  output logic [CHAR_W-1:0] dsp_out_data,
  input  logic              dsp_out_ready
);
  localparam int PAD_W  = DATA_W - CHAR_W;
  localparam int RDY_B  = DATA_W - 1;

  logic              rst_n_s;
  reg_sel_e          sel;
  logic              kb_full;
  logic [CHAR_W-1:0] kb_char;
  logic              dsp_busy;
  logic              kb_consume;
  logic              dsp_load;

  console_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  console_decode #(
    .ADDR_W     (ADDR_W),
    .KSTAT_ADDR (KSTAT_ADDR),
    .KDATA_ADDR (KDATA_ADDR),
    .DSTAT_ADDR (DSTAT_ADDR),
    .DDATA_ADDR (DDATA_ADDR)
  ) u_dec (
    .addr    (bus_addr),
    .rd      (bus_rd),
    .wr      (bus_wr),
    .sel     (sel),
    .mem_sel (mem_sel)
  );

  assign kb_consume = bus_rd & (sel == SEL_KDATA);
  assign dsp_load   = bus_wr & (sel == SEL_DDATA);

  console_kbd #(.CHAR_W(CHAR_W)) u_kbd (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .in_valid (kb_in_valid),
    .in_data  (kb_in_data),
    .in_ready (kb_in_ready),
    .consume  (kb_consume),
    .full     (kb_full),
    .char_q   (kb_char)
  );

  console_dsp #(.CHAR_W(CHAR_W)) u_dsp (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .load      (dsp_load),
    .load_data (bus_wdata[CHAR_W-1:0]),
    .out_valid (dsp_out_valid),
    .out_data  (dsp_out_data),
    .out_ready (dsp_out_ready),
    .busy      (dsp_busy)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      unique case (sel)
        SEL_KSTAT: bus_rdata[RDY_B] = kb_full;
        SEL_KDATA: bus_rdata = {{PAD_W{1'b0}}, kb_char};
        SEL_DSTAT: bus_rdata[RDY_B] = ~dsp_busy;
        default:   bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/console_mmio_chk.sv
module console_mmio_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int CHAR_W = 8,
  parameter logic [ADDR_W-1:0] KSTAT_ADDR = 16'hFE00,
  parameter logic [ADDR_W-1:0] KDATA_ADDR = 16'hFE02,
  parameter logic [ADDR_W-1:0] DSTAT_ADDR = 16'hFE04,
  parameter logic [ADDR_W-1:0] DDATA_ADDR = 16'hFE06
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              mem_sel,
  input logic              kb_in_valid,
  input logic              kb_in_ready,
  input logic              dsp_out_valid,
  input logic [CHAR_W-1:0] dsp_out_data,
  input logic              dsp_out_ready
);
  logic is_reg;
  assign is_reg = (bus_addr == KSTAT_ADDR) || (bus_addr == KDATA_ADDR) ||
                  (bus_addr == DSTAT_ADDR) || (bus_addr == DDATA_ADDR);

  p_kb_take_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (kb_in_valid && kb_in_ready) |=> !kb_in_ready);

  p_kb_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == KDATA_ADDR && !kb_in_ready) |=> kb_in_ready);

  p_kb_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!kb_in_ready && !(bus_rd && bus_addr == KDATA_ADDR)) |=> !kb_in_ready);

  p_dsp_launch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == DDATA_ADDR && !dsp_out_valid) |=>
      (dsp_out_valid && dsp_out_data == $past(bus_wdata[CHAR_W-1:0])));

  p_dsp_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dsp_out_valid && !dsp_out_ready) |=> (dsp_out_valid && $stable(dsp_out_data)));

  p_dsp_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dsp_out_valid && dsp_out_ready) |=> !dsp_out_valid);

  p_dsp_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dsp_out_valid && bus_wr && bus_addr == DDATA_ADDR) |=> $stable(dsp_out_data));

  p_mem_sel_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_sel == ((bus_rd || bus_wr) && !is_reg));

  p_mem_rdata_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && mem_sel) |-> (bus_rdata == '0));
endmodule

bind console_mmio console_mmio_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CHAR_W(CHAR_W),
  .KSTAT_ADDR(KSTAT_ADDR), .KDATA_ADDR(KDATA_ADDR),
  .DSTAT_ADDR(DSTAT_ADDR), .DDATA_ADDR(DDATA_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mem_sel(mem_sel),
  .kb_in_valid(kb_in_valid), .kb_in_ready(kb_in_ready),
  .dsp_out_valid(dsp_out_valid), .dsp_out_data(dsp_out_data),
  .dsp_out_ready(dsp_out_ready)
);

// File: tb/tb_console_mmio.sv
module tb_console_mmio;
  localparam logic [15:0] A_KS = 16'hFE00;
  localparam logic [15:0] A_KD = 16'hFE02;
  localparam logic [15:0] A_DS = 16'hFE04;
  localparam logic [15:0] A_DD = 16'hFE06;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] bus_addr;
  logic        bus_rd, bus_wr;
  logic [15:0] bus_wdata, bus_rdata;
  logic        mem_sel;
  logic        kb_in_valid, kb_in_ready;
  logic [7:0]  kb_in_data;
  logic        dsp_out_valid, dsp_out_ready;
  logic [7:0]  dsp_out_data;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  always #4 clk = ~clk;

  console_mmio dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mem_sel(mem_sel),
    .kb_in_valid(kb_in_valid), .kb_in_data(kb_in_data), .kb_in_ready(kb_in_ready),
    .dsp_out_valid(dsp_out_valid), .dsp_out_data(dsp_out_data), .dsp_out_ready(dsp_out_ready)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog expired after %0d cycles", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_chk = n_chk + 1;
    if (got !== exp) begin
      n_bad = n_bad + 1;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic bus_read(input logic [15:0] a, output logic [15:0] d, output logic ms);
    bus_addr = a; bus_rd = 1'b1;
    #1;
    d = bus_rdata; ms = mem_sel;
    tick();
    bus_rd = 1'b0;
  endtask

  task automatic bus_write(input logic [15:0] a, input logic [15:0] d, output logic ms);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    #1;
    ms = mem_sel;
    tick();
    bus_wr = 1'b0;
  endtask

  initial begin
    logic [15:0] rd;
    logic        ms;
    rst_n = 1'b0; bus_addr = '0; bus_rd = 0; bus_wr = 0; bus_wdata = '0;
    kb_in_valid = 0; kb_in_data = '0; dsp_out_ready = 0;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (3) tick();

    // R1: reset state
    chk("R1 kb ready", {15'b0, kb_in_ready}, 16'h1);
    chk("R1 dsp valid", {15'b0, dsp_out_valid}, 16'h0);
    bus_read(A_KS, rd, ms); chk("R1 kb status", rd, 16'h0000);
    bus_read(A_DS, rd, ms); chk("R1 dsp status", rd, 16'h8000);

    // Keyboard sweep over every byte value
    for (int b = 0; b < 256; b++) begin
      kb_in_valid = 1'b1; kb_in_data = b[7:0];
      #1;
      chk("R3 kb ready before take", {15'b0, kb_in_ready}, 16'h1);
      tick();
      kb_in_data = ~b[7:0];                 // R4: new byte offered while full
      tick();
      chk("R2 kb ready after take", {15'b0, kb_in_ready}, 16'h0);
      chk("R4 kb held off", {15'b0, kb_in_ready}, 16'h0);
      kb_in_valid = 1'b0;
      bus_read(A_KS, rd, ms); chk("R2 kb status full", rd, 16'h8000);
      if (b == 16) begin
        bus_write(A_KS, 16'h0000, ms);      // R8: status write ignored
        bus_write(A_KD, 16'h0055, ms);      // R8: data write ignored
        bus_read(A_KS, rd, ms); chk("R8 kb status after write", rd, 16'h8000);
      end
      bus_read(A_KD, rd, ms); chk("R3 R4 kb data", rd, {8'h00, b[7:0]});
      chk("R3 kb ready after read", {15'b0, kb_in_ready}, 16'h1);
      bus_read(A_KS, rd, ms); chk("R3 kb status empty", rd, 16'h0000);
    end

    // Display sweep over every character with 0..3 stall cycles
    for (int c = 0; c < 256; c++) begin
      dsp_out_ready = 1'b0;
      bus_read(A_DS, rd, ms); chk("R6 dsp status ready", rd, 16'h8000);
      bus_write(A_DD, {~c[7:0], c[7:0]}, ms);
      chk("R5 dsp valid", {15'b0, dsp_out_valid}, 16'h1);
      chk("R5 dsp data", {8'h00, dsp_out_data}, {8'h00, c[7:0]});
      bus_read(A_DS, rd, ms); chk("R5 dsp status busy", rd, 16'h0000);
      bus_write(A_DD, {8'h00, c[7:0] ^ 8'h3C}, ms);
      chk("R7 dsp data kept", {8'h00, dsp_out_data}, {8'h00, c[7:0]});
      bus_write(A_DS, 16'hFFFF, ms);
      bus_read(A_DS, rd, ms); chk("R8 dsp status write ignored", rd, 16'h0000);
      for (int k = 0; k < (c % 4); k++) begin
        tick();
        chk("R6 stall valid", {15'b0, dsp_out_valid}, 16'h1);
        chk("R6 stall data", {8'h00, dsp_out_data}, {8'h00, c[7:0]});
      end
      dsp_out_ready = 1'b1;
      tick();
      dsp_out_ready = 1'b0;
      chk("R6 valid after handshake", {15'b0, dsp_out_valid}, 16'h0);
    end
    bus_read(A_DD, rd, ms); chk("R8 dsp data reads zero", rd, 16'h0000);

    // Address sweep around the console words plus a few far addresses
    for (int a = 16'hFDF8; a <= 16'hFE10; a++) begin
      logic hit;
      hit = (a == A_KS) || (a == A_KD) || (a == A_DS) || (a == A_DD);
      bus_read(a[15:0], rd, ms);
      chk("R9 mem sel read", {15'b0, ms}, {15'b0, ~hit});
      if (!hit) chk("R9 mem rdata zero", rd, 16'h0000);
    end
    bus_read(16'h3000, rd, ms); chk("R9 mem sel low addr", {15'b0, ms}, 16'h1);
    bus_addr = 16'h3000; #1;
    chk("R9 mem sel idle", {15'b0, mem_sel}, 16'h0);
    bus_write(16'hFE07, 16'h0041, ms);
    chk("R9 mem sel write", {15'b0, ms}, 16'h1);
    chk("R9 no display effect", {15'b0, dsp_out_valid}, 16'h0);
    bus_write(A_DD, 16'h0041, ms);
    chk("R9 mem sel reg write", {15'b0, ms}, 16'h0);
    chk("R5 final char", {8'h00, dsp_out_data}, 16'h0041);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule